// File: doc/BRIEF.md
# UART Bit-Timing Fault Monitor

This block listens, without interfering, to the serial transmit line of a sensor whose UART is expected to run at one fixed baud rate. It recovers 8N1 frames: a falling edge on the idle-high line opens a candidate start bit, which is only accepted once the line has stayed low for half a bit period. From that point every data bit and the stop bit are sampled in the middle of their period, least significant bit first. Each good byte is handed downstream as a parallel word with a single-cycle valid strobe, and a busy output marks the time a frame is being received.

While a frame is in progress, the monitor also polices the timing of the line itself. Between two consecutive sampling points the line may change at most once, on the bit boundary. A second transition inside that window means the sender is running faster than configured, and a sticky fault flag is raised on the spot, without waiting for the frame to end. A low stop bit is also a fault. The fault stays latched until a synchronous clear or reset. The raw line is forwarded through a combinational path, so watching it never delays the data seen by the consumer.

Top module: `uart_timing_mon`

## Requirements
- R1: After reset, busy_o, valid_o and fault_o are 0 and data_o is all zeros.
- R2: A low pulse on rx_i shorter than half a bit period (BIT_CLKS/2 clocks, BIT_CLKS = CLK_HZ/BAUD) is ignored: busy_o stays 0, no valid pulse appears and fault_o stays 0.
- R3: busy_o rises once a start bit has been accepted, stays 1 through the data bits and drops after the stop bit is sampled; it is 0 in any cycle where valid_o is 1.
- R4: Data bits are sampled at mid-bit, least significant bit first; 8 data bits, no parity, one stop bit; the byte appears on data_o in the cycle valid_o is 1 and holds until the next good frame.
- R5: Each correctly framed byte yields exactly one valid_o pulse of exactly one clock cycle.
- R6: Two or more transitions of the line between consecutive sampling points of a frame set fault_o within four clocks of the second transition; the frame is abandoned (no valid pulse, busy_o drops).
- R7: A low level sampled at the stop bit position sets fault_o and suppresses the valid pulse.
- R8: fault_o stays 1 until clr_i is 1 at a clock edge or reset; a new fault in the same cycle as clr_i wins and keeps fault_o at 1.
- R9: fwd_o equals rx_i combinationally, with no clock delay.
- R10: The bit length is BIT_CLKS = CLK_HZ/BAUD clocks (default 200 MHz and 57600 baud); a line sent markedly slower than that is misframed and reported as a fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Monitored serial line, idle high |
| clr_i | input | 1 | Synchronous clear of the fault flag |
| fwd_o | output | 1 | Unregistered copy of rx_i |
| busy_o | output | 1 | A frame is being received |
| valid_o | output | 1 | One-cycle strobe for a good byte |
| data_o | output | DATA_BITS | Last good byte, LSB received first |
| fault_o | output | 1 | Sticky timing or framing fault |

## Verification
The hardest condition to reach is a pair of line transitions landing inside one sampling window of an otherwise well-formed frame, since any sender at the right rate never produces it and a merely fast sender also corrupts the framing. The bench shapes the waveform clock by clock: a correct start bit, then a short high pulse placed entirely before the first data sampling point, and it checks that the fault appears within a few clocks and that busy drops at once. A whole frame at twice the rate and one at a slower rate cover the broader mismatch cases.

// File: rtl/uart_mon_pkg.sv
package uart_mon_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/umon_sync.sv
module umon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rx_i,
    output logic line_o,
    output logic fall_o,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.chain = {r_q.chain[STAGES-2:0], rx_i};
        r_d.prev  = r_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_o = r_q.chain[STAGES-1];
    assign fall_o = r_q.prev & ~r_q.chain[STAGES-1];
    assign edge_o = r_q.prev ^ r_q.chain[STAGES-1];
endmodule

// File: rtl/umon_bit_timer.sv
module umon_bit_timer #(
    parameter int BIT_CLKS = 3472
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic half_o,
    output logic full_o
);
    localparam int CW = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CW-1:0] HALF_M1 = CW'(BIT_CLKS / 2 - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(BIT_CLKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_regs_t;

    timer_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (restart_i || r_q.cnt == FULL_M1) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign half_o = (r_q.cnt == HALF_M1);
    assign full_o = (r_q.cnt == FULL_M1);
endmodule

// File: rtl/umon_edge_guard.sv
module umon_edge_guard (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    input  logic edge_i,
    input  logic sample_i,
    output logic viol_o
);
    typedef struct packed {
        logic seen;
    } guard_regs_t;

    guard_regs_t r_d, r_q;
    logic        viol;

    always_comb begin
        r_d  = r_q;
        viol = 1'b0;
        if (!active_i) begin
            r_d.seen = 1'b0;
        end else if (sample_i) begin
            r_d.seen = edge_i;
        end else begin
            viol     = r_q.seen & edge_i;
            r_d.seen = r_q.seen | edge_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign viol_o = viol;
endmodule

// File: rtl/umon_frame_ctrl.sv
module umon_frame_ctrl
    import uart_mon_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 line_i,
    input  logic                 fall_i,
    input  logic                 half_i,
    input  logic                 full_i,
    input  logic                 viol_i,
    input  logic                 clr_i,
    output logic                 restart_o,
    output logic                 active_o,
    output logic                 sample_o,
    output logic                 busy_o,
    output logic                 valid_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 fault_o,
    output logic                 fault_set_o
);
    localparam int IW = $clog2(DATA_BITS + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_BITS - 1);

    typedef struct packed {
        rx_state_e            state;
        logic [IW-1:0]        idx;
        logic [DATA_BITS-1:0] shift;
        logic [DATA_BITS-1:0] data;
        logic                 valid;
        logic                 fault;
    } frame_regs_t;

    frame_regs_t r_d, r_q;
    logic        restart;
    logic        stop_err;
    logic        active;

    assign active = (r_q.state == ST_DATA) || (r_q.state == ST_STOP);

    always_comb begin
        r_d      = r_q;
        r_d.valid = 1'b0;
        restart  = 1'b0;
        stop_err = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                restart = 1'b1;
                if (fall_i) begin
                    r_d.state = ST_START;
                end
            end
            ST_START: begin
                if (line_i) begin
                    r_d.state = ST_IDLE;
                    restart   = 1'b1;
                end else if (half_i) begin
                    r_d.state = ST_DATA;
                    r_d.idx   = '0;
                    restart   = 1'b1;
                end
            end
            ST_DATA: begin
                if (viol_i) begin
                    r_d.state = ST_IDLE;
                end else if (full_i) begin
                    r_d.shift = {line_i, r_q.shift[DATA_BITS-1:1]};
                    if (r_q.idx == LAST_IDX) begin
                        r_d.state = ST_STOP;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (viol_i) begin
                    r_d.state = ST_IDLE;
                end else if (full_i) begin
                    r_d.state = ST_IDLE;
                    if (line_i) begin
                        r_d.valid = 1'b1;
                        r_d.data  = r_q.shift;
                    end else begin
                        stop_err = 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (viol_i || stop_err) begin
            r_d.fault = 1'b1;
        end else if (clr_i) begin
            r_d.fault = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign restart_o   = restart;
    assign active_o    = active;
    assign sample_o    = active & full_i;
    assign busy_o      = active;
    assign valid_o     = r_q.valid;
    assign data_o      = r_q.data;
    assign fault_o     = r_q.fault;
    assign fault_set_o = viol_i | stop_err;
endmodule

// File: rtl/uart_timing_mon.sv
module uart_timing_mon #(
    parameter int CLK_HZ      = 200_000_000,
    parameter int BAUD        = 57_600,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 rx_i,
    input  logic                 clr_i,
    output logic                 fwd_o,
    output logic                 busy_o,
    output logic                 valid_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 fault_o
);
    localparam int BIT_CLKS = CLK_HZ / BAUD;

    logic line, fall, edge_s;
    logic half, full, restart;
    logic active, sample, viol;
    logic fault_set;

    // Forwarded path bypasses every register of the monitor
    assign fwd_o = rx_i;

    umon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rx_i   (rx_i),
        .line_o (line),
        .fall_o (fall),
        .edge_o (edge_s)
    );

    umon_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .half_o    (half),
        .full_o    (full)
    );

    umon_edge_guard u_guard (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (active),
        .edge_i   (edge_s),
        .sample_i (sample),
        .viol_o   (viol)
    );

    umon_frame_ctrl #(.DATA_BITS(DATA_BITS)) u_frame (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .line_i      (line),
        .fall_i      (fall),
        .half_i      (half),
        .full_i      (full),
        .viol_i      (viol),
        .clr_i       (clr_i),
        .restart_o   (restart),
        .active_o    (active),
        .sample_o    (sample),
        .busy_o      (busy_o),
        .valid_o     (valid_o),
        .data_o      (data_o),
        .fault_o     (fault_o),
        .fault_set_o (fault_set)
    );
endmodule

// File: rtl/uart_timing_mon_chk.sv
module uart_timing_mon_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic clr_i,
    input logic busy_o,
    input logic valid_o,
    input logic fault_o,
    input logic fault_set
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o); // R5

    AST_VALID_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> !busy_o); // R3

    AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_o && !clr_i) |=> fault_o); // R8

    AST_FAULT_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_set |=> fault_o); // R8

    AST_FAULT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !fault_set) |=> !fault_o); // R8

    AST_FAULT_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fault_o) |-> $past(busy_o)); // R6
endmodule

bind uart_timing_mon uart_timing_mon_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .busy_o    (busy_o),
    .valid_o   (valid_o),
    .fault_o   (fault_o),
    .fault_set (fault_set)
);

// File: tb/uart_timing_mon_tb.sv
`timescale 1ns/1ps
module uart_timing_mon_tb;
    localparam int BL = 16; // 200 MHz / 12.5 MBd

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       clr = 1'b0;
    logic       fwd, busy, valid, fault;
    logic [7:0] data;

    int total = 0;
    int bad = 0;
    int vcount = 0;
    logic [7:0] vdata = '0;
    logic [7:0] vprev = '0;
    logic busy_seen = 1'b0;

    always #2.5 clk = ~clk;

    uart_timing_mon #(.CLK_HZ(200_000_000), .BAUD(12_500_000)) u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .rx_i    (rx),
        .clr_i   (clr),
        .fwd_o   (fwd),
        .busy_o  (busy),
        .valid_o (valid),
        .data_o  (data),
        .fault_o (fault)
    );

    always @(negedge clk) begin
        if (valid) begin
            vcount <= vcount + 1;
            vprev  <= vdata;
            vdata  <= data;
        end
        if (busy) busy_seen <= 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input int bl, input logic stopv, input bit chk_busy);
        rx = 1'b0;
        repeat (bl) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = d[i];
            repeat (bl) @(negedge clk);
            if (chk_busy && i == 2) check(busy == 1'b1, "R3 busy mid-frame", busy, 1);
        end
        rx = stopv;
        repeat (bl) @(negedge clk);
        rx = 1'b1;
    endtask

    task automatic pulse_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(valid == 1'b0, "R1 valid", valid, 0);
        check(fault == 1'b0, "R1 fault", fault, 0);
        check(data == 8'h00, "R1 data", data, 0);
    endtask

    task automatic t_forward();
        #1 rx = 1'b0;
        #0.5 check(fwd == 1'b0, "R9 fwd low", fwd, 0);
        rx = 1'b1;
        #0.5 check(fwd == 1'b1, "R9 fwd high", fwd, 1);
        @(negedge clk);
    endtask

    task automatic t_good(input logic [7:0] d);
        int v0 = vcount;
        send_frame(d, BL, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        check(vcount == v0 + 1, "R5 one valid pulse", vcount - v0, 1);
        check(vdata == d, "R4 byte value", vdata, d);
        check(busy == 1'b0, "R3 busy after stop", busy, 0);
        check(fault == 1'b0, "R10 no fault at rate", fault, 0);
    endtask

    task automatic t_back_to_back();
        int v0 = vcount;
        send_frame(8'h12, BL, 1'b1, 1'b0);
        send_frame(8'h34, BL, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        check(vcount == v0 + 2, "R5 two pulses", vcount - v0, 2);
        check(vprev == 8'h12, "R4 first byte", vprev, 8'h12);
        check(vdata == 8'h34, "R4 second byte", vdata, 8'h34);
    endtask

    task automatic t_glitch();
        int v0 = vcount;
        busy_seen = 1'b0;
        rx = 1'b0;
        repeat (6) @(negedge clk);
        rx = 1'b1;
        repeat (40) @(negedge clk);
        check(busy_seen == 1'b0, "R2 glitch no busy", busy_seen, 0);
        check(vcount == v0, "R2 glitch no valid", vcount - v0, 0);
        check(fault == 1'b0, "R2 glitch no fault", fault, 0);
    endtask

    task automatic t_double_edge();
        int v0 = vcount;
        rx = 1'b0;
        repeat (BL) @(negedge clk);
        repeat (2) @(negedge clk);
        rx = 1'b1;
        repeat (3) @(negedge clk);
        rx = 1'b0;
        repeat (4) @(negedge clk);
        check(fault == 1'b1, "R6 fault prompt", fault, 1);
        check(busy == 1'b0, "R6 frame abandoned", busy, 0);
        repeat (60) @(negedge clk);
        rx = 1'b1;
        repeat (200) @(negedge clk);
        check(fault == 1'b1, "R8 fault held", fault, 1);
        check(vcount == v0, "R6 no valid", vcount - v0, 0);
        pulse_clear();
        check(fault == 1'b0, "R8 clear", fault, 0);
    endtask

    task automatic t_fast();
        int v0 = vcount;
        send_frame(8'h54, BL / 2, 1'b1, 1'b0);
        repeat (BL * 2) @(negedge clk);
        check(fault == 1'b1, "R6 double rate", fault, 1);
        check(vcount == v0, "R6 double rate no valid", vcount - v0, 0);
        pulse_clear();
    endtask

    task automatic t_slow();
        int v0 = vcount;
        send_frame(8'h00, BL + BL / 4, 1'b1, 1'b0);
        repeat (BL * 2) @(negedge clk);
        check(fault == 1'b1, "R10 slow rate", fault, 1);
        check(vcount == v0, "R10 slow no valid", vcount - v0, 0);
        pulse_clear();
    endtask

    task automatic t_stop_err();
        int v0 = vcount;
        send_frame(8'h3C, BL, 1'b0, 1'b0);
        repeat (BL) @(negedge clk);
        check(fault == 1'b1, "R7 stop low", fault, 1);
        check(vcount == v0, "R7 no valid", vcount - v0, 0);
        pulse_clear();
        check(fault == 1'b0, "R8 clear after stop", fault, 0);
        t_good(8'hC3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_forward();
        t_good(8'hA5);
        t_good(8'h00);
        t_good(8'hFF);
        t_good(8'h81);
        t_back_to_back();
        t_glitch();
        t_double_edge();
        t_fast();
        t_slow();
        t_stop_err();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule